// File: doc/BRIEF.md
# Flash Lane Sequencer with Read-Opcode Snooping

This block moves bytes between a transmit FIFO, a receive FIFO and one or two serial flash lanes. After a start strobe it pops transmit bytes, hands each one to a lane through a request/done handshake, and pushes the byte that lane returns into the receive FIFO. The run continues until the transmit FIFO runs dry.

While a chip select is held, the block decodes the first byte it sends as a flash command. Fast-read commands carry a fixed prologue of address, mode and dummy bytes. The block counts these prologue byte groups. Until the count runs out, every active lane carries the same byte. After the count, each lane takes its own byte from the FIFO. This lets a pair of flash devices deliver data bytes side by side. In single-lane configurations, lane 0 alone is used and the decoder has no visible effect.

Top module: `flash_lane_sequencer`

## Requirements
- R1: Both lanes are used only when `cfgSplitBus` and `cfgDualMem` are both high. In every other configuration, only lane 0 (`busReq[0]`) is ever requested.
- R2: When not in split mode, one byte is popped per group and offered on the active lanes in order, lane 0 and then lane 1. Lane i carries its byte on `busTx[8i+7:8i]`. Only the byte returned by lane 0 is pushed to the receive FIFO.
- R3: The byte of the first group sent after a chip-select assertion is decoded. 0x0B, 0x6B and 0xBB are each followed by 4 further broadcast groups. 0xEB is followed by 6. Split mode then starts and stays on. Any other value keeps broadcast mode until the chip select is released.
- R4: In split mode, lane 0 pops its own byte, exchanges it and pushes its returned byte. Lane 1 then does the same with the next byte.
- R5: A low `csActive` returns the decoder to its decode state. While `csActive` stays high, the decoder state carries over from one start to the next.
- R6: When a lane needs a new byte and `txEmpty` is high, the block raises `underflowEvt` for one cycle and pops nothing. It then issues no request and no pop until the next `startPulse`. Every run ends this way.
- R7: If `rxFull` is high when a returned byte is due to be pushed, the byte is dropped and `overflowEvt` pulses for one cycle. The run then continues.
- R8: At most one `busReq` bit is high at any time. A request is held until the same lane's `busDone`. The next exchange starts only after that.
- R9: While reset is asserted, no request, pop, push or event output is active.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| cfgSplitBus | input | 1 | Separate-lane wiring selected |
| cfgDualMem | input | 1 | Two flash devices fitted |
| csActive | input | 1 | High while any chip select is asserted |
| startPulse | input | 1 | Starts a run when idle |
| txData | input | 8 | Head byte of the transmit FIFO |
| txEmpty | input | 1 | Transmit FIFO is empty |
| txPop | output | 1 | Consumes the head byte of the transmit FIFO |
| rxData | output | 8 | Byte to push into the receive FIFO |
| rxFull | input | 1 | Receive FIFO is full |
| rxPush | output | 1 | Writes `rxData` into the receive FIFO |
| busReq | output | 2 | Per-lane exchange request |
| busTx | output | 16 | Per-lane byte to send, lane i at bits 8i+7:8i |
| busRx | input | 16 | Per-lane returned byte, lane i at bits 8i+7:8i |
| busDone | input | 2 | Per-lane exchange complete, one cycle |
| underflowEvt | output | 1 | One-cycle pulse: a needed transmit byte was missing |
| overflowEvt | output | 1 | One-cycle pulse: a returned byte was dropped |

## Verification
A decoder in the wrong state shows up in the first group after the point where split mode should begin or end. Lane 1 then carries a copy of lane 0's byte instead of the next FIFO byte, or the reverse. The receive FIFO also gains one byte more or fewer per group. A lane counter that is off by one shows at once: the wrong `busReq` bit goes high, or a returned byte that should be pushed is dropped. The bench replays each run against an arithmetic model of the decoder, so a wrong state is caught within one exchange.

// File: rtl/flseq_pkg.sv
package flseq_pkg;

  // Strobes from the control FSM to the datapath.
  typedef struct packed {
    logic loadTx;   // capture the head byte of the transmit FIFO
    logic laneClr;  // return the lane pointer to lane 0
    logic laneInc;  // step to the next lane
  } lane_ctl_t;

  // Command decoder states.
  typedef enum logic [1:0] {
    SN_DECODE,   // next completed group carries a command byte
    SN_PLAIN,    // not a fast read: broadcast until chip select drops
    SN_SPLIT,    // prologue over: each lane takes its own byte
    SN_COUNT     // counting prologue groups
  } snoop_e;

  // Sequencer states.
  typedef enum logic [1:0] {
    SQ_IDLE,
    SQ_FETCH,
    SQ_XFER
  } seq_e;

endpackage

// File: rtl/fl_snoop.sv
module fl_snoop
  import flseq_pkg::*;
#(
  parameter int DATA_W    = 8,
  parameter int SHORT_LEN = 4,
  parameter int LONG_LEN  = 6,
  parameter logic [DATA_W-1:0] OP_SHORT_A = 8'h0B,
  parameter logic [DATA_W-1:0] OP_SHORT_B = 8'h6B,
  parameter logic [DATA_W-1:0] OP_SHORT_C = 8'hBB,
  parameter logic [DATA_W-1:0] OP_LONG    = 8'hEB
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              csActive,
  input  logic              groupDone,
  input  logic [DATA_W-1:0] lastByte,
  output logic              striping
);

  localparam int CNT_W = $clog2(LONG_LEN + 1);

  snoop_e           snoopState;
  logic [CNT_W-1:0] prologueLeft;
  logic             isShortOp;
  logic             isLongOp;

  assign isShortOp = (lastByte == OP_SHORT_A) || (lastByte == OP_SHORT_B) ||
                     (lastByte == OP_SHORT_C);
  assign isLongOp  = (lastByte == OP_LONG);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      snoopState   <= SN_DECODE;
      prologueLeft <= '0;
    end else if (!csActive) begin
      snoopState   <= SN_DECODE;
      prologueLeft <= '0;
    end else if (groupDone) begin
      unique case (snoopState)
        SN_DECODE: begin
          if (isShortOp) begin
            snoopState   <= SN_COUNT;
            prologueLeft <= CNT_W'(SHORT_LEN);
          end else if (isLongOp) begin
            snoopState   <= SN_COUNT;
            prologueLeft <= CNT_W'(LONG_LEN);
          end else begin
            snoopState   <= SN_PLAIN;
          end
        end
        SN_COUNT: begin
          if (prologueLeft == CNT_W'(1)) snoopState <= SN_SPLIT;
          else prologueLeft <= prologueLeft - CNT_W'(1);
        end
        default: ;
      endcase
    end
  end

  assign striping = (snoopState == SN_SPLIT);

endmodule

// File: rtl/fl_datapath.sv
module fl_datapath
  import flseq_pkg::*;
#(
  parameter int NUM_BUS = 2,
  parameter int DATA_W  = 8,
  parameter int LANE_W  = 1
) (
  input  logic                      clk,
  input  logic                      rstN,
  input  lane_ctl_t                 ctl,
  input  logic                      allLanes,
  input  logic [DATA_W-1:0]         txData,
  input  logic [NUM_BUS*DATA_W-1:0] busRx,
  output logic [LANE_W-1:0]         laneIdx,
  output logic                      laneLast,
  output logic [DATA_W-1:0]         lastByte,
  output logic [NUM_BUS*DATA_W-1:0] busTx,
  output logic [DATA_W-1:0]         rxData
);

  localparam logic [LANE_W-1:0] LAST_LANE = LANE_W'(NUM_BUS - 1);

  logic [DATA_W-1:0] byteReg;
  logic [DATA_W-1:0] rxLane [NUM_BUS];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) byteReg <= '0;
    else if (ctl.loadTx) byteReg <= txData;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) laneIdx <= '0;
    else if (ctl.laneClr) laneIdx <= '0;
    else if (ctl.laneInc) laneIdx <= laneIdx + LANE_W'(1);
  end

  assign laneLast = allLanes ? (laneIdx == LAST_LANE) : (laneIdx == '0);

  // The held byte goes to every lane; only the requested lane uses it.
  for (genvar g = 0; g < NUM_BUS; g++) begin : g_lane
    assign busTx[g*DATA_W +: DATA_W] = byteReg;
    assign rxLane[g] = busRx[g*DATA_W +: DATA_W];
  end

  assign rxData   = rxLane[laneIdx];
  assign lastByte = byteReg;

endmodule

// File: rtl/fl_ctrl.sv
module fl_ctrl
  import flseq_pkg::*;
#(
  parameter int NUM_BUS = 2,
  parameter int LANE_W  = 1
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               startPulse,
  input  logic               txEmpty,
  input  logic               rxFull,
  input  logic [NUM_BUS-1:0] busDone,
  input  logic [LANE_W-1:0]  laneIdx,
  input  logic               laneLast,
  input  logic               striping,
  output lane_ctl_t          ctl,
  output logic               txPop,
  output logic               rxPush,
  output logic [NUM_BUS-1:0] busReq,
  output logic               underflowEvt,
  output logic               overflowEvt,
  output logic               groupDone
);

  seq_e seqState, seqNext;
  logic needByte;
  logic laneDone;

  // Lane 0 always takes a fresh byte; other lanes only while splitting.
  assign needByte = (laneIdx == '0) || striping;
  assign laneDone = busDone[laneIdx];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) seqState <= SQ_IDLE;
    else seqState <= seqNext;
  end

  always_comb begin
    for (int i = 0; i < NUM_BUS; i++) begin
      busReq[i] = (seqState == SQ_XFER) && (laneIdx == LANE_W'(i));
    end
  end

  always_comb begin
    seqNext      = seqState;
    ctl          = '0;
    txPop        = 1'b0;
    rxPush       = 1'b0;
    underflowEvt = 1'b0;
    overflowEvt  = 1'b0;
    groupDone    = 1'b0;
    unique case (seqState)
      SQ_IDLE: begin
        if (startPulse) begin
          seqNext     = SQ_FETCH;
          ctl.laneClr = 1'b1;
        end
      end
      SQ_FETCH: begin
        if (needByte && txEmpty) begin
          underflowEvt = 1'b1;
          ctl.laneClr  = 1'b1;
          seqNext      = SQ_IDLE;
        end else begin
          txPop      = needByte;
          ctl.loadTx = needByte;
          seqNext    = SQ_XFER;
        end
      end
      SQ_XFER: begin
        if (laneDone) begin
          if (needByte) begin
            rxPush      = !rxFull;
            overflowEvt = rxFull;
          end
          if (laneLast) begin
            groupDone   = 1'b1;
            ctl.laneClr = 1'b1;
          end else begin
            ctl.laneInc = 1'b1;
          end
          seqNext = SQ_FETCH;
        end
      end
      default: seqNext = SQ_IDLE;
    endcase
  end

endmodule

// File: rtl/flash_lane_sequencer.sv
module flash_lane_sequencer
  import flseq_pkg::*;
#(
  parameter int NUM_BUS = 2,
  parameter int DATA_W  = 8
) (
  input  logic                      clk,
  input  logic                      rstN,
  input  logic                      cfgSplitBus,
  input  logic                      cfgDualMem,
  input  logic                      csActive,
  input  logic                      startPulse,
  input  logic [DATA_W-1:0]         txData,
  input  logic                      txEmpty,
  output logic                      txPop,
  output logic [DATA_W-1:0]         rxData,
  input  logic                      rxFull,
  output logic                      rxPush,
  output logic [NUM_BUS-1:0]        busReq,
  output logic [NUM_BUS*DATA_W-1:0] busTx,
  input  logic [NUM_BUS*DATA_W-1:0] busRx,
  input  logic [NUM_BUS-1:0]        busDone,
  output logic                      underflowEvt,
  output logic                      overflowEvt
);

  localparam int LANE_W = (NUM_BUS > 1) ? $clog2(NUM_BUS) : 1;

  lane_ctl_t         ctl;
  logic [LANE_W-1:0] laneIdx;
  logic              laneLast;
  logic              striping;
  logic              groupDone;
  logic [DATA_W-1:0] lastByte;
  logic              allLanes;

  assign allLanes = cfgSplitBus & cfgDualMem;

  fl_ctrl #(.NUM_BUS(NUM_BUS), .LANE_W(LANE_W)) u_ctrl (
    .clk(clk), .rstN(rstN), .startPulse(startPulse), .txEmpty(txEmpty),
    .rxFull(rxFull), .busDone(busDone), .laneIdx(laneIdx), .laneLast(laneLast),
    .striping(striping), .ctl(ctl), .txPop(txPop), .rxPush(rxPush),
    .busReq(busReq), .underflowEvt(underflowEvt), .overflowEvt(overflowEvt),
    .groupDone(groupDone)
  );

  fl_datapath #(.NUM_BUS(NUM_BUS), .DATA_W(DATA_W), .LANE_W(LANE_W)) u_dp (
    .clk(clk), .rstN(rstN), .ctl(ctl), .allLanes(allLanes), .txData(txData),
    .busRx(busRx), .laneIdx(laneIdx), .laneLast(laneLast), .lastByte(lastByte),
    .busTx(busTx), .rxData(rxData)
  );

  fl_snoop #(.DATA_W(DATA_W)) u_snoop (
    .clk(clk), .rstN(rstN), .csActive(csActive), .groupDone(groupDone),
    .lastByte(lastByte), .striping(striping)
  );

endmodule

// File: rtl/flseq_checker.sv
module flseq_checker #(
  parameter int NUM_BUS = 2
) (
  input logic               clk,
  input logic               rstN,
  input logic               cfgSplitBus,
  input logic               cfgDualMem,
  input logic               txEmpty,
  input logic               txPop,
  input logic               rxFull,
  input logic               rxPush,
  input logic [NUM_BUS-1:0] busReq,
  input logic [NUM_BUS-1:0] busDone,
  input logic               underflowEvt,
  input logic               overflowEvt
);

  p_single_lane_r1: assert property (@(posedge clk) disable iff (!rstN)
    !(cfgSplitBus && cfgDualMem) |-> ((busReq >> 1) == '0));

  p_pop_has_data_r6: assert property (@(posedge clk) disable iff (!rstN)
    txPop |-> !txEmpty);

  p_underflow_no_pop_r6: assert property (@(posedge clk) disable iff (!rstN)
    underflowEvt |-> (txEmpty && !txPop));

  p_stop_after_underflow_r6: assert property (@(posedge clk) disable iff (!rstN)
    underflowEvt |=> (busReq == '0));

  p_no_overflow_push_r7: assert property (@(posedge clk) disable iff (!rstN)
    rxPush |-> !rxFull);

  p_overflow_drops_r7: assert property (@(posedge clk) disable iff (!rstN)
    overflowEvt |-> (rxFull && !rxPush));

  p_one_request_r8: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0(busReq));

  p_request_held_r8: assert property (@(posedge clk) disable iff (!rstN)
    ((busReq & ~busDone) != '0) |=> (busReq == $past(busReq)));

endmodule

bind flash_lane_sequencer flseq_checker #(.NUM_BUS(NUM_BUS)) u_flseq_chk (
  .clk(clk), .rstN(rstN), .cfgSplitBus(cfgSplitBus), .cfgDualMem(cfgDualMem),
  .txEmpty(txEmpty), .txPop(txPop), .rxFull(rxFull), .rxPush(rxPush),
  .busReq(busReq), .busDone(busDone), .underflowEvt(underflowEvt),
  .overflowEvt(overflowEvt)
);

// File: tb/tb_flash_lane_sequencer.sv
module tb_flash_lane_sequencer;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        cfgSplitBus = 1'b0;
  logic        cfgDualMem = 1'b0;
  logic        csActive = 1'b0;
  logic        startPulse = 1'b0;
  logic [7:0]  txData = '0;
  logic        txEmpty = 1'b1;
  logic        txPop;
  logic [7:0]  rxData;
  logic        rxFull = 1'b0;
  logic        rxPush;
  logic [1:0]  busReq;
  logic [15:0] busTx;
  logic [15:0] busRx = '0;
  logic [1:0]  busDone = '0;
  logic        underflowEvt;
  logic        overflowEvt;

  always #10 clk = ~clk;

  flash_lane_sequencer dut (
    .clk(clk), .rstN(rstN), .cfgSplitBus(cfgSplitBus), .cfgDualMem(cfgDualMem),
    .csActive(csActive), .startPulse(startPulse), .txData(txData),
    .txEmpty(txEmpty), .txPop(txPop), .rxData(rxData), .rxFull(rxFull),
    .rxPush(rxPush), .busReq(busReq), .busTx(busTx), .busRx(busRx),
    .busDone(busDone), .underflowEvt(underflowEvt), .overflowEvt(overflowEvt)
  );

  int checks = 0;
  int errors = 0;

  // Bench FIFOs, exchange log and event counters.
  logic [7:0] txq [0:4095];
  int head = 0, tail = 0;
  logic [7:0] rxLog [0:8191];
  int rxCnt = 0, rxCap = 1000000;
  int exLane [0:8191];
  logic [7:0] exByte [0:8191];
  logic [7:0] exReply [0:8191];
  int exN = 0;
  int underCnt = 0, overCnt = 0, popCnt = 0, overlapCnt = 0;
  // Decoder model: 0 decode, 1 plain, 2 split, 3 counting.
  int mS = 0, mCnt = 0;

  task automatic check(input bit ok, input string req, input string what,
                       input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  // Drives FIFO status and lane responses at negedge; samples the outputs
  // the design will act on at the next posedge.
  initial begin
    logic pPop, pPush, pUnder, pOver, doneGiven;
    logic [1:0] pReq;
    logic [7:0] pRxData;
    int waitCnt;
    pPop = 0; pPush = 0; pUnder = 0; pOver = 0; pReq = '0; pRxData = '0;
    doneGiven = 0; waitCnt = 0;
    forever begin
      @(negedge clk);
      if (pPop) begin head++; popCnt++; end
      if (pPush) begin rxLog[rxCnt] = pRxData; rxCnt++; end
      if (pUnder) underCnt++;
      if (pOver) overCnt++;
      if ($countones(pReq) > 1) overlapCnt++;
      busDone = '0;
      if (doneGiven) doneGiven = 0;
      else if (pReq != '0) begin
        if (waitCnt >= exN % 3) begin
          int l;
          logic [7:0] reply;
          l = pReq[1] ? 1 : 0;
          reply = 8'h3C ^ 8'(exN * 5) ^ 8'(l * 8'h81);
          busRx[l*8 +: 8] = reply;
          busDone[l] = 1'b1;
          exLane[exN] = l;
          exByte[exN] = busTx[l*8 +: 8];
          exReply[exN] = reply;
          exN++;
          waitCnt = 0;
          doneGiven = 1;
        end else waitCnt++;
      end
      txData = txq[head];
      txEmpty = (head == tail);
      rxFull = (rxCnt >= rxCap);
      #1;
      pPop = txPop; pPush = rxPush; pRxData = rxData;
      pUnder = underflowEvt; pOver = overflowEvt; pReq = busReq;
    end
  end

  task automatic loadBytes(input logic [7:0] op, input int n);
    txq[tail] = op; tail++;
    for (int k = 1; k < n; k++) begin
      txq[tail] = 8'(op + k * 13 + 7);
      tail++;
    end
  endtask

  task automatic csRelease();
    @(negedge clk); csActive = 1'b0;
    repeat (2) @(negedge clk);
    csActive = 1'b1;
    mS = 0; mCnt = 0;
  endtask

  task automatic runCheck(input string tag);
    int base, n, ex0, rx0, ov0, un0, p, e, pushes, stored, space, wd, lanes;
    bit dual, stop, split, need;
    logic [7:0] cur;
    int expPush [0:255];
    dual = cfgSplitBus && cfgDualMem;
    base = head; n = tail - head; ex0 = exN; rx0 = rxCnt; ov0 = overCnt;
    un0 = underCnt;
    @(negedge clk); startPulse = 1'b1;
    @(negedge clk); startPulse = 1'b0;
    wd = 0;
    while (underCnt == un0 && wd < 4000) begin @(negedge clk); wd++; end
    repeat (3) @(negedge clk);
    check(underCnt - un0 == 1, tag, "underflow pulses ending run (R6)",
          underCnt - un0, 1);
    p = 0; e = ex0; pushes = 0; stop = 0; cur = '0;
    while (!stop && e < ex0 + 400) begin
      split = dual && (mS == 2);
      lanes = dual ? 2 : 1;
      for (int l = 0; l < lanes && !stop; l++) begin
        need = (l == 0) || split;
        if (need && p == n) stop = 1;
        else begin
          if (need) begin cur = txq[base + p]; p++; end
          check(exLane[e] == l && exByte[e] == cur, tag, "lane*256+byte",
                exLane[e] * 256 + int'(exByte[e]), l * 256 + int'(cur));
          if (need && pushes < 256) begin expPush[pushes] = int'(exReply[e]); pushes++; end
          e++;
        end
      end
      if (!stop) begin
        if (mS == 0) begin
          if (cur == 8'h0B || cur == 8'h6B || cur == 8'hBB) begin mS = 3; mCnt = 4; end
          else if (cur == 8'hEB) begin mS = 3; mCnt = 6; end
          else mS = 1;
        end else if (mS == 3) begin
          if (mCnt == 1) mS = 2; else mCnt--;
        end
      end
    end
    check(exN == e, tag, "exchange count", exN - ex0, e - ex0);
    space = rxCap - rx0;
    if (space < 0) space = 0;
    stored = (pushes < space) ? pushes : space;
    check(rxCnt - rx0 == stored, tag, "pushed byte count", rxCnt - rx0, stored);
    for (int i = 0; i < stored; i++)
      check(int'(rxLog[rx0 + i]) == expPush[i], tag, "pushed byte value",
            int'(rxLog[rx0 + i]), expPush[i]);
    check(overCnt - ov0 == pushes - stored, tag, "overflow pulses (R7)",
          overCnt - ov0, pushes - stored);
  endtask

  initial begin
    logic [7:0] ops [6];
    int lens [4];
    int pc, ec;
    ops = '{8'h0B, 8'h6B, 8'hBB, 8'hEB, 8'h03, 8'h00};
    lens = '{5, 8, 11, 12};
    repeat (2) @(negedge clk);
    // R9: outputs quiet while reset is asserted
    check(busReq == '0, "R9", "busReq in reset", int'(busReq), 0);
    check(!txPop && !rxPush, "R9", "pop/push in reset", int'({txPop, rxPush}), 0);
    check(!underflowEvt && !overflowEvt, "R9", "events in reset",
          int'({underflowEvt, overflowEvt}), 0);
    @(negedge clk); rstN = 1'b1;

    // Sweep of configurations, command bytes and run lengths (R1..R4).
    for (int cfg = 0; cfg < 4; cfg++) begin
      cfgSplitBus = cfg[0];
      cfgDualMem = cfg[1];
      for (int o = 0; o < 6; o++) begin
        for (int li = 0; li < 4; li++) begin
          csRelease();
          loadBytes(ops[o], lens[li]);
          if (cfg != 3) runCheck("R1");
          else if (o >= 4) runCheck("R2");
          else runCheck("R3/R4");
        end
      end
    end

    // R5: decoder state carries over while CS held, clears on release.
    cfgSplitBus = 1'b1; cfgDualMem = 1'b1;
    csRelease();
    loadBytes(8'hEB, 3);
    runCheck("R5");
    loadBytes(8'h11, 9);
    runCheck("R5");
    csRelease();
    loadBytes(8'h6B, 10);
    runCheck("R5");

    // R6: idle after underflow until the next start.
    loadBytes(8'h21, 4);
    pc = popCnt; ec = exN;
    repeat (12) @(negedge clk);
    check(popCnt == pc, "R6", "pops while idle", popCnt - pc, 0);
    check(exN == ec, "R6", "exchanges while idle", exN - ec, 0);
    runCheck("R6");

    // R7: receive FIFO fills partway through a run.
    csRelease();
    rxCap = rxCnt + 3;
    loadBytes(8'hEB, 12);
    runCheck("R7");
    cfgSplitBus = 1'b0;
    csRelease();
    rxCap = rxCnt + 2;
    loadBytes(8'h03, 6);
    runCheck("R7");
    rxCap = 1000000;

    check(overlapCnt == 0, "R8", "cycles with two requests", overlapCnt, 0);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule